// File: doc/BRIEF.md
# Multiple-Register Transfer Address Sequencer

This block takes one request to move a group of registers to or from memory and breaks it into one word access per register. A request carries a base address, a 16-bit mask of the registers to move, one of four stepping modes, a direction flag and a flag asking for the base to be updated. The sequencer then presents the addresses one at a time, each paired with the number of the register that belongs at that address. A ready/valid handshake with the memory side paces the transfers.

Whatever the mode, the registers are visited from the lowest number to the highest, and the addresses rise by one word (4 bytes) per transfer. The mode only decides where the run of addresses sits relative to the base, so the lowest-numbered register always lands at the lowest address. When the last transfer is accepted the block pulses a completion flag. It also presents the updated base value and a flag saying whether that value is to be written back.

Top module: `lsm_addr_seq`

## Requirements
- R1: `mode_i` selects where the address run starts: 0 = step up after each access (first address = base), 1 = step up before each access (base+4), 2 = step down after each access (base-4N+4), 3 = step down before each access (base-4N). N is the number of set bits in `list_i`. All arithmetic wraps modulo 2^32.
- R2: Each accepted transfer is followed by a transfer whose address is 4 higher than the previous one.
- R3: Registers are visited in ascending index order, one per set bit of `list_i`. `xfer_reg_o` carries the 4-bit index of the current register, so the lowest set bit is paired with the lowest address.
- R4: While `xfer_valid_o` is high and `xfer_ready_i` is low, the valid signal, the address and the register index hold their values.
- R5: `done_o` is high for exactly one cycle, the cycle after the last transfer is accepted, and `xfer_valid_o` and `busy_o` are low in that cycle.
- R6: When `done_o` is high, `fin_base_o` holds base+4N for modes 0 and 1 and base-4N for modes 2 and 3.
- R7: `wb_o` is high only in the `done_o` cycle, and only when `wb_i` was high with the accepted start.
- R8: A start with an all-zero list makes no transfer. `done_o` goes high in the cycle after the start, and `fin_base_o` equals the base.
- R9: A start that arrives while `busy_o` is high is ignored: the transfer sequence already running, and its completion values, are unchanged.
- R10: `xfer_load_o` equals the `load_i` value captured at the accepted start for the whole sequence.
- R11: After reset, `xfer_valid_o`, `busy_o`, `done_o` and `wb_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken when not busy |
| base_i | input | 32 | Base address of the request |
| list_i | input | 16 | Register mask, bit i selects register i |
| mode_i | input | 2 | Stepping mode, encoded as in R1 |
| load_i | input | 1 | 1 = memory to registers, 0 = registers to memory |
| wb_i | input | 1 | Request base update at completion |
| xfer_ready_i | input | 1 | Memory side accepts the current transfer |
| xfer_valid_o | output | 1 | A transfer is presented |
| xfer_addr_o | output | 32 | Word address of the current transfer |
| xfer_reg_o | output | 4 | Register index of the current transfer |
| xfer_load_o | output | 1 | Direction of the running request |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wb_o | output | 1 | Base update requested, valid with done_o |
| fin_base_o | output | 32 | Updated base value, valid with done_o |

## Verification
The bench runs each of the four modes with sparse lists whose gaps show whether registers are skipped or reordered. A design that mixed up the before/after or up/down meaning would shift the whole address run by one word or by the span. A design that walked registers from high to low in a decrementing mode would pair the wrong index with each address. Stalls on the ready input catch an address that advances without acceptance. A full 16-register list in a decrementing mode from a small base forces the address to wrap. An empty list and a stray start in the middle of a sequence check that the block does not hang and that an ignored request does not corrupt the one in flight.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

  typedef enum logic [1:0] {
    MODE_UP_AFTER    = 2'd0,
    MODE_UP_BEFORE   = 2'd1,
    MODE_DOWN_AFTER  = 2'd2,
    MODE_DOWN_BEFORE = 2'd3
  } lsm_mode_e;

  function automatic logic mode_goes_down(lsm_mode_e m);
    return (m == MODE_DOWN_AFTER) || (m == MODE_DOWN_BEFORE);
  endfunction

  function automatic logic mode_steps_first(lsm_mode_e m);
    return (m == MODE_UP_BEFORE) || (m == MODE_DOWN_BEFORE);
  endfunction

endpackage

// File: rtl/lsm_span_calc.sv
module lsm_span_calc
  import lsm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NREG   = 16,
  parameter int STEP   = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [NREG-1:0]   list,
  input  lsm_mode_e         mode,
  output logic [ADDR_W-1:0] first_addr,
  output logic [ADDR_W-1:0] final_base,
  output logic              empty
);
  localparam int CNT_W = $clog2(NREG + 1);

  function automatic logic [CNT_W-1:0] count_set(logic [NREG-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < NREG; i++) c = c + CNT_W'(v[i]);
    return c;
  endfunction

  function automatic logic [ADDR_W-1:0] span_bytes(logic [CNT_W-1:0] n);
    return ADDR_W'(n) * ADDR_W'(STEP);
  endfunction

  logic [CNT_W-1:0]  n_regs;
  logic [ADDR_W-1:0] span;
  logic              down;
  logic              pre;

  assign n_regs = count_set(list);
  assign span   = span_bytes(n_regs);
  assign down   = mode_goes_down(mode);
  assign pre    = mode_steps_first(mode);
  assign empty  = (n_regs == '0);

  always_comb begin
    if (down) begin
      first_addr = base - span + (pre ? '0 : ADDR_W'(STEP));
      final_base = base - span;
    end else begin
      first_addr = base + (pre ? ADDR_W'(STEP) : '0);
      final_base = base + span;
    end
  end
endmodule

// File: rtl/lsm_pick_low.sv
module lsm_pick_low #(
  parameter int NREG  = 16,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0]  mask,
  output logic [NREG-1:0]  onehot,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  logic [NREG:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NREG; i++) begin : g_chain
    assign seen[i+1]  = seen[i] | mask[i];
    assign onehot[i]  = mask[i] & ~seen[i];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NREG; i++) begin
      if (onehot[i]) idx = idx | IDX_W'(i);
    end
  end

  assign last = seen[NREG] && ((mask & ~onehot) == '0);
endmodule

// File: rtl/lsm_addr_seq.sv
module lsm_addr_seq
  import lsm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NREG   = 16,
  parameter int STEP   = 4,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [NREG-1:0]   list_i,
  input  logic [1:0]        mode_i,
  input  logic              load_i,
  input  logic              wb_i,
  input  logic              xfer_ready_i,
  output logic              xfer_valid_o,
  output logic [ADDR_W-1:0] xfer_addr_o,
  output logic [IDX_W-1:0]  xfer_reg_o,
  output logic              xfer_load_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              wb_o,
  output logic [ADDR_W-1:0] fin_base_o
);
  logic              busy_q, done_q, load_q, wb_q;
  logic [NREG-1:0]   mask_q;
  logic [ADDR_W-1:0] addr_q, fin_q;

  logic [ADDR_W-1:0] calc_first, calc_final;
  logic              calc_empty;
  logic [NREG-1:0]   cur_onehot;
  logic [IDX_W-1:0]  cur_idx;
  logic              cur_last;

  // named events used by the bound checker
  logic start_take;
  logic step_fire;
  logic step_last;

  lsm_span_calc #(.ADDR_W(ADDR_W), .NREG(NREG), .STEP(STEP)) u_span (
    .base       (base_i),
    .list       (list_i),
    .mode       (lsm_mode_e'(mode_i)),
    .first_addr (calc_first),
    .final_base (calc_final),
    .empty      (calc_empty)
  );

  lsm_pick_low #(.NREG(NREG), .IDX_W(IDX_W)) u_pick (
    .mask   (mask_q),
    .onehot (cur_onehot),
    .idx    (cur_idx),
    .last   (cur_last)
  );

  assign start_take = start_i && !busy_q;
  assign step_fire  = busy_q && xfer_ready_i;
  assign step_last  = step_fire && cur_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      load_q <= 1'b0;
      wb_q   <= 1'b0;
      mask_q <= '0;
      addr_q <= '0;
      fin_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_take) begin
        load_q <= load_i;
        wb_q   <= wb_i;
        fin_q  <= calc_final;
        mask_q <= list_i;
        addr_q <= calc_first;
        if (calc_empty) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
        end
      end else if (step_fire) begin
        mask_q <= mask_q & ~cur_onehot;
        addr_q <= addr_q + ADDR_W'(STEP);
        if (cur_last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign xfer_valid_o = busy_q;
  assign xfer_addr_o  = addr_q;
  assign xfer_reg_o   = cur_idx;
  assign xfer_load_o  = load_q;
  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign wb_o         = done_q & wb_q;
  assign fin_base_o   = fin_q;
endmodule

// File: rtl/lsm_addr_seq_chk.sv
module lsm_addr_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int NREG   = 16,
  parameter int STEP   = 4,
  localparam int IDX_W = $clog2(NREG)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              xfer_ready_i,
  input logic              xfer_valid_o,
  input logic [ADDR_W-1:0] xfer_addr_o,
  input logic [IDX_W-1:0]  xfer_reg_o,
  input logic              xfer_load_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              wb_o,
  input logic [ADDR_W-1:0] fin_base_o,
  input logic              start_take,
  input logic              step_fire,
  input logic              step_last
);
  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !step_last) |=> (xfer_valid_o && xfer_addr_o == $past(xfer_addr_o) + ADDR_W'(STEP)));

  assert_reg_ascend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !step_last) |=> (xfer_reg_o > $past(xfer_reg_o)));

  assert_hold_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && !xfer_ready_i) |=>
      (xfer_valid_o && $stable(xfer_addr_o) && $stable(xfer_reg_o)));

  assert_done_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_last |=> (done_o && !xfer_valid_o && !busy_o));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_take) |=> !done_o);

  assert_fin_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !start_i) |=> $stable(fin_base_o));

  assert_wb_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_o |-> done_o);

  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !step_last) |=> busy_o);

  assert_load_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !step_last) |=> $stable(xfer_load_o));
endmodule

bind lsm_addr_seq lsm_addr_seq_chk #(.ADDR_W(ADDR_W), .NREG(NREG), .STEP(STEP)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .xfer_ready_i (xfer_ready_i),
  .xfer_valid_o (xfer_valid_o),
  .xfer_addr_o  (xfer_addr_o),
  .xfer_reg_o   (xfer_reg_o),
  .xfer_load_o  (xfer_load_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .wb_o         (wb_o),
  .fin_base_o   (fin_base_o),
  .start_take   (start_take),
  .step_fire    (step_fire),
  .step_last    (step_last)
);

// File: tb/sim_lsm_addr_seq.sv
module sim_lsm_addr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] list_i = '0;
  logic [1:0]  mode_i = '0;
  logic        load_i = 1'b0;
  logic        wb_i = 1'b0;
  logic        xfer_ready_i = 1'b0;
  logic        xfer_valid_o;
  logic [31:0] xfer_addr_o;
  logic [3:0]  xfer_reg_o;
  logic        xfer_load_o;
  logic        busy_o;
  logic        done_o;
  logic        wb_o;
  logic [31:0] fin_base_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  lsm_addr_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i), .list_i(list_i),
    .mode_i(mode_i), .load_i(load_i), .wb_i(wb_i), .xfer_ready_i(xfer_ready_i),
    .xfer_valid_o(xfer_valid_o), .xfer_addr_o(xfer_addr_o), .xfer_reg_o(xfer_reg_o),
    .xfer_load_o(xfer_load_o), .busy_o(busy_o), .done_o(done_o), .wb_o(wb_o),
    .fin_base_o(fin_base_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  // Runs one request; expected values derived from the requirements.
  task automatic run_req(input logic [31:0] base, input logic [15:0] list, input logic [1:0] mode,
                         input bit ld, input bit wb, input int stall_mod, input bit poke);
    int n;
    int k;
    int ptr;
    int cyc;
    logic [31:0] low;
    logic [31:0] top;
    logic [31:0] fin;
    bit rdy;
    n = $countones(list);
    // R1: decreasing modes place the run so that its top word is base (after) or base-4 (before)
    if (mode[1]) begin
      top = mode[0] ? base - 32'd4 : base;
      low = top - 32'(4 * (n - 1));
      fin = base - 32'(4 * n);
    end else begin
      low = mode[0] ? base + 32'd4 : base;
      fin = base + 32'(4 * n);
    end
    @(negedge clk);
    start_i = 1'b1; base_i = base; list_i = list; mode_i = mode; load_i = ld; wb_i = wb;
    xfer_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    k = 0;
    ptr = 0;
    cyc = 0;
    while (k < n && cyc < 400) begin
      if (poke && cyc == 0) begin
        start_i = 1'b1; base_i = 32'h0BAD_0000; list_i = 16'h0000; mode_i = 2'd1;
        load_i = ~ld; wb_i = ~wb;
      end else begin
        start_i = 1'b0;
      end
      rdy = (stall_mod == 0) || ((cyc % stall_mod) != 0);
      xfer_ready_i = rdy;
      if (!xfer_valid_o) begin
        chk(1'b0, "R3", "valid dropped early", {31'd0, xfer_valid_o}, 32'd1);
        break;
      end
      if (k == 0 && cyc == 0)
        chk(xfer_load_o == ld, "R10", "direction flag", {31'd0, xfer_load_o}, {31'd0, ld});
      if (rdy) begin
        while (ptr < 16 && !list[ptr]) ptr++;
        chk(xfer_addr_o == low + 32'(4 * k), (k == 0) ? "R1" : "R2", "address",
            xfer_addr_o, low + 32'(4 * k));
        chk(xfer_reg_o == 4'(ptr), "R3", "register index", {28'd0, xfer_reg_o}, 32'(ptr));
        ptr++;
        k++;
      end else if (cyc > 0) begin
        chk(xfer_addr_o == low + 32'(4 * k), "R4", "address held in stall",
            xfer_addr_o, low + 32'(4 * k));
      end
      cyc++;
      @(negedge clk);
    end
    start_i = 1'b0;
    xfer_ready_i = 1'b0;
    chk(done_o && !xfer_valid_o && !busy_o, "R5", "done after last accept",
        {29'd0, done_o, xfer_valid_o, busy_o}, 32'h4);
    chk(fin_base_o == fin, "R6", "final base", fin_base_o, fin);
    chk(wb_o == wb, poke ? "R9" : "R7", "writeback flag", {31'd0, wb_o}, {31'd0, wb});
    chk(xfer_load_o == ld, poke ? "R9" : "R10", "direction kept", {31'd0, xfer_load_o}, {31'd0, ld});
    @(negedge clk);
    chk(!done_o && !wb_o, "R5", "done single cycle", {30'd0, done_o, wb_o}, 32'd0);
  endtask

  task automatic t_reset();
    chk(!xfer_valid_o && !busy_o && !done_o && !wb_o, "R11", "reset outputs",
        {28'd0, xfer_valid_o, busy_o, done_o, wb_o}, 32'd0);
  endtask

  task automatic t_up_after();    run_req(32'h0000_1000, 16'b0000_0100_1010_0001, 2'd0, 1'b1, 1'b1, 0, 1'b0); endtask
  task automatic t_up_before();   run_req(32'h2000_0040, 16'b1000_0000_0001_0110, 2'd1, 1'b0, 1'b1, 0, 1'b0); endtask
  task automatic t_down_after();  run_req(32'h0000_8000, 16'b0101_0000_1000_0010, 2'd2, 1'b1, 1'b0, 0, 1'b0); endtask
  task automatic t_down_before(); run_req(32'h0000_8000, 16'b0000_1100_0000_1001, 2'd3, 1'b0, 1'b1, 0, 1'b0); endtask
  task automatic t_stall();       run_req(32'h0040_0100, 16'b0011_0000_0000_1100, 2'd1, 1'b1, 1'b1, 3, 1'b0); endtask
  task automatic t_full_wrap();   run_req(32'h0000_0008, 16'hFFFF, 2'd3, 1'b1, 1'b1, 0, 1'b0); endtask
  task automatic t_single();      run_req(32'hFFFF_FFFC, 16'h8000, 2'd1, 1'b0, 1'b0, 2, 1'b0); endtask
  task automatic t_busy_start();  run_req(32'h0000_3000, 16'b0000_0000_1111_0000, 2'd2, 1'b1, 1'b1, 0, 1'b1); endtask

  task automatic t_empty();
    @(negedge clk);
    start_i = 1'b1; base_i = 32'h1234_5670; list_i = 16'h0000; mode_i = 2'd3; wb_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o && !xfer_valid_o && !busy_o, "R8", "empty list completes",
        {29'd0, done_o, xfer_valid_o, busy_o}, 32'h4);
    chk(fin_base_o == 32'h1234_5670, "R8", "empty list final base", fin_base_o, 32'h1234_5670);
    @(negedge clk);
    chk(!done_o && !xfer_valid_o, "R8", "empty list idle", {30'd0, done_o, xfer_valid_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_up_after();
    t_up_before();
    t_down_after();
    t_down_before();
    t_stall();
    t_full_wrap();
    t_single();
    t_busy_start();
    t_empty();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule